// File: doc/BRIEF.md
# Dual-Bus 8-Bit Processor Datapath

This block is the data-moving half of a small stored-program controller. It holds four general registers, an operand register, a one-bit zero flag, a program counter, an instruction register, an address register and a 256-word read/write memory. Two chained buses move the data. A five-way source multiplexer drives bus 1 from one general register or the program counter. A four-way multiplexer drives bus 2 from the ALU result, bus 1, the memory word, or zero. Bus 2 is the only path into any register.

A sequencer outside the block drives all the selects, strobes and the ALU operation code. It applies one set of controls per clock and reads back the instruction register and the zero flag. Every register transfer, ALU step and memory access happens in a single clock cycle. The memory read is combinational from the address register, so the addressed word can be captured in the same cycle.

Top module: `dbus_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears all general registers, the operand register, the zero flag, the program counter, the instruction register and the address register. The memory contents are left as they are.
- R2: Bus 1 carries general register k when `b1_sel` is k (0 to 3) and the program counter when `b1_sel` is 4. Codes 5 to 7 drive zero.
- R3: Bus 2 carries the ALU result when `b2_sel` is 0, bus 1 when it is 1, the memory word at the address register when it is 2, and zero when it is 3.
- R4: The ALU combines the operand register Y with bus 1 B. `alu_op` 0 passes B, 1 gives Y+B, 2 gives Y−B, 3 gives Y AND B and 4 gives NOT B. Codes 5 to 7 give zero. Arithmetic is modulo 256.
- R5: When `ld_z` is high, `zero_q` takes 1 if the ALU result is zero and 0 otherwise. When `ld_z` is low, the flag holds.
- R6: When `mem_we` is high, bus 1 is written at the address held in the address register. The address register loads from bus 2 on `ld_ar`, and a read presents the addressed word to bus 2 in the same cycle.
- R7: The program counter loads from bus 2 on `ld_pc` and adds 1 modulo 256 on `inc_pc`. When both strobes are high, the load wins.
- R8: General register k loads from bus 2 when `ld_gpr[k]` is high, and Y loads from bus 2 on `ld_y`. Without its strobe, each register holds its value.
- R9: The instruction register loads from bus 2 when `ld_ir` is high and holds otherwise. It is visible on `ir_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| b1_sel | input | 3 | Bus 1 source select |
| b2_sel | input | 2 | Bus 2 source select |
| alu_op | input | 3 | ALU operation code |
| ld_gpr | input | 4 | Load strobes for general registers 0 to 3 |
| ld_y | input | 1 | Operand register load |
| ld_z | input | 1 | Zero flag load |
| ld_ir | input | 1 | Instruction register load |
| ld_pc | input | 1 | Program counter load from bus 2 |
| inc_pc | input | 1 | Program counter increment |
| ld_ar | input | 1 | Address register load |
| mem_we | input | 1 | Memory write enable |
| ir_q | output | 8 | Instruction register contents |
| zero_q | output | 1 | Zero flag |

## Verification
Some behaviour is checked by the assertions on every cycle. These are the reset values, the instruction register and zero flag holding without their strobes, the instruction register capturing bus 2, the zero flag matching the ALU result it sampled, and the program counter load, increment and priority. Other behaviour can only be shown by the bench scenarios, which route values to the instruction register. These are the bus source encodings, each ALU operation against arithmetic computed in the bench, memory write and read-back across every address, and general registers holding their values through unrelated traffic.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  typedef enum logic [1:0] {
    B2_ALU  = 2'd0,
    B2_BUS1 = 2'd1,
    B2_MEM  = 2'd2,
    B2_ZERO = 2'd3
  } b2_src_e;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_NOT  = 3'd4
  } alu_op_e;
endpackage

// File: rtl/dbp_gpr.sv
module dbp_gpr #(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NREG-1:0]           ld,
  input  logic [DW-1:0]             d,
  output logic [NREG-1:0][DW-1:0]   q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= '0;
      else if (ld[g]) q[g] <= d;
    end
  end
endmodule

// File: rtl/dbp_alu.sv
module dbp_alu
  import dbp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    case (alu_op_e'(op))
      OP_PASS: y = b;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_NOT:  y = ~b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dbp_ram.sv
module dbp_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/dbus_datapath.sv
module dbus_datapath
  import dbp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 4,
  parameter int SW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW-1:0]   b1_sel,
  input  logic [1:0]      b2_sel,
  input  logic [2:0]      alu_op,
  input  logic [NREG-1:0] ld_gpr,
  input  logic            ld_y,
  input  logic            ld_z,
  input  logic            ld_ir,
  input  logic            ld_pc,
  input  logic            inc_pc,
  input  logic            ld_ar,
  input  logic            mem_we,
  output logic [DW-1:0]   ir_q,
  output logic            zero_q
);
  logic [NREG-1:0][DW-1:0] gpr_q;
  logic [DW-1:0] y_q, pc_q, ar_q;
  logic [DW-1:0] bus1, bus2, alu_y, mem_rd;

  dbp_gpr #(.DW(DW), .NREG(NREG)) u_gpr (
    .clk(clk), .rst(rst), .ld(ld_gpr), .d(bus2), .q(gpr_q)
  );

  dbp_alu #(.DW(DW)) u_alu (
    .op(alu_op), .a(y_q), .b(bus1), .y(alu_y)
  );

  dbp_ram #(.DW(DW), .AW(DW)) u_ram (
    .clk(clk), .we(mem_we), .addr(ar_q), .wdata(bus1), .rdata(mem_rd)
  );

  always_comb begin
    bus1 = '0;
    for (int i = 0; i < NREG; i++) begin
      if (b1_sel == SW'(i)) bus1 = gpr_q[i];
    end
    if (b1_sel == SW'(NREG)) bus1 = pc_q;
  end

  always_comb begin
    case (b2_src_e'(b2_sel))
      B2_ALU:  bus2 = alu_y;
      B2_BUS1: bus2 = bus1;
      B2_MEM:  bus2 = mem_rd;
      default: bus2 = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q    <= '0;
      zero_q <= 1'b0;
      pc_q   <= '0;
      ir_q   <= '0;
      ar_q   <= '0;
    end else begin
      if (ld_y)  y_q    <= bus2;
      if (ld_z)  zero_q <= (alu_y == '0);
      if (ld_ir) ir_q   <= bus2;
      if (ld_ar) ar_q   <= bus2;
      if (ld_pc)       pc_q <= bus2;
      else if (inc_pc) pc_q <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/dbp_chk.sv
module dbp_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_ir,
  input logic          ld_z,
  input logic          ld_pc,
  input logic          inc_pc,
  input logic [DW-1:0] ir_q,
  input logic          zero_q,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] bus2,
  input logic [DW-1:0] alu_y
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ir_q == '0 && !zero_q && pc_q == '0));

  p_ir_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ld_ir |=> $stable(ir_q));

  p_ir_load_r9: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> ir_q == $past(bus2));

  p_z_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ld_z |=> $stable(zero_q));

  p_z_load_r5: assert property (@(posedge clk) disable iff (rst)
    ld_z |=> zero_q == ($past(alu_y) == '0));

  p_pc_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ld_pc |=> pc_q == $past(bus2));

  p_pc_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (inc_pc && !ld_pc) |=> pc_q == DW'($past(pc_q) + 1'b1));

  p_pc_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!inc_pc && !ld_pc) |=> $stable(pc_q));
endmodule

bind dbus_datapath dbp_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ld_ir(ld_ir), .ld_z(ld_z), .ld_pc(ld_pc),
  .inc_pc(inc_pc), .ir_q(ir_q), .zero_q(zero_q), .pc_q(pc_q),
  .bus2(bus2), .alu_y(alu_y)
);

// File: tb/dbus_datapath_tb.sv
module dbus_datapath_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] b1_sel;
  logic [1:0] b2_sel;
  logic [2:0] alu_op;
  logic [3:0] ld_gpr;
  logic       ld_y, ld_z, ld_ir, ld_pc, inc_pc, ld_ar, mem_we;
  logic [7:0] ir_q;
  logic       zero_q;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dbus_datapath u_dut (
    .clk(clk), .rst(rst), .b1_sel(b1_sel), .b2_sel(b2_sel), .alu_op(alu_op),
    .ld_gpr(ld_gpr), .ld_y(ld_y), .ld_z(ld_z), .ld_ir(ld_ir), .ld_pc(ld_pc),
    .inc_pc(inc_pc), .ld_ar(ld_ar), .mem_we(mem_we), .ir_q(ir_q), .zero_q(zero_q)
  );

  task automatic idle();
    b1_sel = 3'd0; b2_sel = 2'd0; alu_op = 3'd0; ld_gpr = 4'd0;
    ld_y = 0; ld_z = 0; ld_ir = 0; ld_pc = 0; inc_pc = 0; ld_ar = 0; mem_we = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic set_pc(input int v);
    ld_pc = 1; b2_sel = 2'd3; tick();
    for (int i = 0; i < v; i++) begin inc_pc = 1; tick(); end
  endtask

  task automatic load_reg(input int k, input int v);
    set_pc(v); b1_sel = 3'd4; b2_sel = 2'd1; ld_gpr[k] = 1'b1; tick();
  endtask

  task automatic load_y(input int v);
    set_pc(v); b1_sel = 3'd4; b2_sel = 2'd1; ld_y = 1; tick();
  endtask

  task automatic peek(input logic [2:0] sel);
    b1_sel = sel; b2_sel = 2'd1; ld_ir = 1; tick();
  endtask

  function automatic logic [7:0] alu_ref(input int op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      0: return b;
      1: return 8'(a + b);
      2: return 8'(a - b);
      3: return a & b;
      4: return ~b;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] avals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h3C};
    logic [7:0] rv [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    idle();
    rst = 1; tick(); tick(); rst = 0;

    // R1 reset state
    check8("R1 ir after reset", ir_q, 8'h00);
    check8("R1 zero after reset", {7'd0, zero_q}, 8'h00);
    peek(3'd4); check8("R1 pc after reset", ir_q, 8'h00);
    for (int k = 0; k < 4; k++) begin peek(3'(k)); check8("R1 gpr after reset", ir_q, 8'h00); end

    // R8 loads, R2 bus 1 selection
    for (int k = 0; k < 4; k++) load_reg(k, rv[k]);
    for (int k = 0; k < 4; k++) begin peek(3'(k)); check8("R2 bus1 gpr select", ir_q, rv[k]); end
    for (int s = 5; s < 8; s++) begin peek(3'(s)); check8("R2 unused bus1 code", ir_q, 8'h00); end

    // R9 hold without strobe
    peek(3'd1);
    b1_sel = 3'd2; b2_sel = 2'd1; tick();
    check8("R9 ir holds", ir_q, rv[1]);

    // R3 bus 2 sources
    b2_sel = 2'd3; ld_ir = 1; tick(); check8("R3 bus2 zero code", ir_q, 8'h00);
    b1_sel = 3'd1; b2_sel = 2'd0; alu_op = 3'd0; ld_ir = 1; tick();
    check8("R3 bus2 alu pass", ir_q, rv[1]);

    // R7 wrap, priority, increment
    set_pc(255); inc_pc = 1; tick(); peek(3'd4); check8("R7 pc wraps", ir_q, 8'h00);
    b1_sel = 3'd2; b2_sel = 2'd1; ld_pc = 1; inc_pc = 1; tick();
    peek(3'd4); check8("R7 load beats increment", ir_q, rv[2]);
    inc_pc = 1; tick(); peek(3'd4); check8("R7 increment", ir_q, 8'(rv[2] + 1));

    // R8 registers held through traffic
    for (int k = 0; k < 4; k++) begin peek(3'(k)); check8("R8 gpr holds", ir_q, rv[k]); end

    // R6 memory sweep: write each address with its own index
    set_pc(0);
    for (int a = 0; a < 256; a++) begin
      b1_sel = 3'd4; b2_sel = 2'd1; ld_ar = 1; tick();
      b1_sel = 3'd4; mem_we = 1; inc_pc = 1; tick();
    end
    b1_sel = 3'd3; b2_sel = 2'd1; ld_gpr[0] = 1'b0; tick();
    set_pc(16); b1_sel = 3'd4; b2_sel = 2'd1; ld_ar = 1; tick();
    b1_sel = 3'd3; mem_we = 1; tick();
    set_pc(0);
    for (int a = 0; a < 256; a++) begin
      b1_sel = 3'd4; b2_sel = 2'd1; ld_ar = 1; tick();
      b2_sel = 2'd2; ld_ir = 1; inc_pc = 1; tick();
      check8("R6 memory read back", ir_q, (a == 16) ? rv[3] : 8'(a));
    end

    // R4 and R5 ALU sweep: Y fixed, B from the program counter
    foreach (avals[i]) begin
      load_y(avals[i]);
      set_pc(0);
      for (int b = 0; b < 256; b++) begin
        for (int op = 0; op < 8; op++) begin
          b1_sel = 3'd4; b2_sel = 2'd0; alu_op = 3'(op); ld_ir = 1; ld_z = 1; tick();
          check8("R4 alu result", ir_q, alu_ref(op, avals[i], 8'(b)));
          check8("R5 zero flag", {7'd0, zero_q}, {7'd0, alu_ref(op, avals[i], 8'(b)) == 8'h00});
        end
        inc_pc = 1; tick();
      end
    end

    // R5 hold without strobe
    alu_op = 3'd5; ld_z = 1; tick();
    check8("R5 zero set", {7'd0, zero_q}, 8'h01);
    b1_sel = 3'd5; b2_sel = 2'd0; alu_op = 3'd4; ld_ir = 1; tick();
    check8("R5 alu not of zero bus", ir_q, 8'hFF);
    check8("R5 flag holds", {7'd0, zero_q}, 8'h01);
    b1_sel = 3'd5; alu_op = 3'd4; ld_z = 1; tick();
    check8("R5 flag clears", {7'd0, zero_q}, 8'h00);

    // R1 reset mid-run
    rst = 1; tick(); rst = 0;
    check8("R1 ir cleared", ir_q, 8'h00);
    check8("R1 zero cleared", {7'd0, zero_q}, 8'h00);
    peek(3'd4); check8("R1 pc cleared", ir_q, 8'h00);
    for (int k = 0; k < 4; k++) begin peek(3'(k)); check8("R1 gpr cleared", ir_q, 8'h00); end
    b1_sel = 3'd5; b2_sel = 2'd0; alu_op = 3'd1; ld_ir = 1; tick();
    check8("R1 y cleared", ir_q, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule